// File: doc/BRIEF.md
# Global-History Branch Predictor with Target Buffer

This block predicts the direction and next PC of conditional branches in a 32-bit RISC-V pipeline model. Each resolved branch arrives as one request. The request carries the branch PC, whether the branch was really taken and the PC that really followed it. The block answers with the direction it would have predicted, the next PC it would have predicted, and a flag that says whether that prediction was right. In the same clock edge it trains itself on the real outcome, so the next request sees the updated state.

Direction comes from a table of 2-bit saturating counters. The table is indexed by a hash of the PC with an 8-bit global history of recent outcomes. The target comes from a direct-mapped buffer that is tagged with the upper PC bits. The response is registered and appears one cycle after the request.

Top module: `bp_gshare_unit`

## Requirements
- R1: A synchronous active-high reset clears all direction counters, the history and every target-buffer valid bit, and drives `rsp_valid` low. The first request after reset is therefore predicted not-taken with next PC equal to PC+4.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. A cycle with `req_valid` low changes no predictor state.
- R3: The direction counter is selected by `req_pc[9:2]` XOR the 8-bit history. A counter value of 2 or 3 predicts taken, and 0 or 1 predicts not-taken.
- R4: The selected counter increments on an actually-taken branch, up to 3 at most. It decrements on a not-taken branch, down to 0 at least. The counter is selected with the history as it was before this request.
- R5: After each request the history shifts left by one bit, and the actual outcome enters bit 0.
- R6: The target buffer is indexed by `req_pc[9:2]`, and each entry holds a valid bit, the tag `req_pc[31:10]` and a 32-bit target. An entry is written, with the actual next PC, only on an actually-taken branch.
- R7: The predicted next PC is the buffered target when taken is predicted and the entry is valid with a matching tag. In every other case it is PC+4.
- R8: `rsp_correct` is high when the predicted direction equals the actual one and, if taken was predicted, the predicted next PC also equals the actual next PC.
- R9: Every prediction uses the state from before its own request. Back-to-back requests each see all the updates made by earlier requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A resolved branch is presented this cycle |
| req_pc | input | 32 | Branch PC |
| req_taken | input | 1 | Actual direction |
| req_next_pc | input | 32 | Actual next PC |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_pred_taken | output | 1 | Predicted direction |
| rsp_pred_next_pc | output | 32 | Predicted next PC |
| rsp_correct | output | 1 | Prediction matched in direction and, if taken, in target |

## Verification
The bench drives branches whose PCs share an index but differ in tag. A design that ignored the tag would then return a stale target and mark a wrong prediction as correct. Long runs of taken branches followed by not-taken branches drive the counters against both saturation limits, where a design that wraps would flip its direction. Not-taken branches are mixed in at PCs that were already stored, so a buffer that is written on every branch would lose the targets it had kept. Requests arrive back to back and between idle gaps, so a design that updates with the shifted history, or that reads state that is one request late, gives the wrong direction.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] sat2_t;

  localparam sat2_t SAT_MAX = 2'd3;
  localparam sat2_t SAT_MIN = 2'd0;

  function automatic logic sat2_predicts(input sat2_t c);
    return c[1];
  endfunction

  function automatic sat2_t sat2_train(input sat2_t c, input logic up);
    if (up)
      return (c == SAT_MAX) ? SAT_MAX : c + 2'd1;
    else
      return (c == SAT_MIN) ? SAT_MIN : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)
      hist_q <= '0;
    else if (upd_en)
      hist_q <= {hist_q[HIST_W-2:0], upd_taken};
  end

  assign hist_o = hist_q;

  // R2: an idle cycle leaves the history untouched
  a_r2_hist_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(hist_q));
endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             pred_taken_o,
  input  logic             upd_en,
  input  logic             upd_taken
);
  localparam int DEPTH = 1 << IDX_W;

  sat2_t ctr_q [DEPTH];
  sat2_t rd_ctr;

  assign rd_ctr       = ctr_q[idx];
  assign pred_taken_o = sat2_predicts(rd_ctr);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= SAT_MIN;
    end else if (upd_en) begin
      ctr_q[idx] <= sat2_train(rd_ctr, upd_taken);
    end
  end

  // R4: saturation at the top and bottom
  a_r4_sat_top: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_taken && rd_ctr == SAT_MAX) |=> ctr_q[$past(idx)] == SAT_MAX);
  a_r4_sat_bottom: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_taken && rd_ctr == SAT_MIN) |=> ctr_q[$past(idx)] == SAT_MIN);
endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc,
  output logic            hit_o,
  output logic [XLEN-1:0] target_o,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_target
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = XLEN - IDX_W - 2;

  logic [IDX_W-1:0] slot;
  logic [TAG_W-1:0] tag;
  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [XLEN-1:0]  tgt_mem [DEPTH];

  assign slot = pc[IDX_W+1:2];
  assign tag  = pc[XLEN-1:IDX_W+2];

  // valid bits need a reset; tag and target arrays stay plain RAM
  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= '0;
    else if (wr_en)
      valid_q[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[slot] <= tag;
      tgt_mem[slot] <= wr_target;
    end
  end

  assign hit_o    = valid_q[slot] && (tag_mem[slot] == tag);
  assign target_o = tgt_mem[slot];

  // R6: without a write the valid bits cannot change
  a_r6_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(valid_q));
  // R6: a write leaves the addressed entry a hit for the same PC
  a_r6_write_hits: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(slot)]);
endmodule

// File: rtl/bp_gshare_unit.sv
module bp_gshare_unit
  import bp_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int HIST_W    = 8,
  parameter int BTB_IDX_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_pc,
  input  logic            req_taken,
  input  logic [XLEN-1:0] req_next_pc,
  output logic            rsp_valid,
  output logic            rsp_pred_taken,
  output logic [XLEN-1:0] rsp_pred_next_pc,
  output logic            rsp_correct
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] pht_idx;
  logic              dir_taken;
  logic              btb_hit;
  logic [XLEN-1:0]   btb_target;
  logic [XLEN-1:0]   pred_next;
  logic              pred_ok;

  bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst),
    .upd_en(req_valid), .upd_taken(req_taken),
    .hist_o(hist)
  );

  // the index uses the history as it stands before this request shifts it
  assign pht_idx = req_pc[HIST_W+1:2] ^ hist;

  bp_pattern_table #(.IDX_W(HIST_W)) u_pht (
    .clk(clk), .rst(rst),
    .idx(pht_idx), .pred_taken_o(dir_taken),
    .upd_en(req_valid), .upd_taken(req_taken)
  );

  bp_target_buffer #(.XLEN(XLEN), .IDX_W(BTB_IDX_W)) u_btb (
    .clk(clk), .rst(rst),
    .pc(req_pc), .hit_o(btb_hit), .target_o(btb_target),
    .wr_en(req_valid && req_taken), .wr_target(req_next_pc)
  );

  assign pred_next = (dir_taken && btb_hit) ? btb_target : req_pc + INSN_BYTES;
  assign pred_ok   = (dir_taken == req_taken) &&
                     (!dir_taken || (pred_next == req_next_pc));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid        <= 1'b0;
      rsp_pred_taken   <= 1'b0;
      rsp_pred_next_pc <= '0;
      rsp_correct      <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pred_taken   <= dir_taken;
        rsp_pred_next_pc <= pred_next;
        rsp_correct      <= pred_ok;
      end
    end
  end

  // R2: no response without a request
  a_r2_idle_no_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R8: a correct response agrees with the real direction
  a_r8_correct_dir: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_correct || rsp_pred_taken == $past(req_taken)));
  // R7: a not-taken prediction always points at the next sequential PC
  a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_pred_taken || rsp_pred_next_pc == $past(req_pc) + INSN_BYTES));
endmodule

// File: tb/test_bp_gshare_unit.sv
module test_bp_gshare_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_pc;
  logic        req_taken;
  logic [31:0] req_next_pc;
  logic        rsp_valid;
  logic        rsp_pred_taken;
  logic [31:0] rsp_pred_next_pc;
  logic        rsp_correct;

  bp_gshare_unit i_bp_gshare_unit (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_pc(req_pc), .req_taken(req_taken),
    .req_next_pc(req_next_pc),
    .rsp_valid(rsp_valid), .rsp_pred_taken(rsp_pred_taken),
    .rsp_pred_next_pc(rsp_pred_next_pc), .rsp_correct(rsp_correct)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural model state
  int          m_ctr   [256];
  bit [7:0]    m_hist;
  bit          m_valid [256];
  bit [21:0]   m_tag   [256];
  bit [31:0]   m_tgt   [256];

  bit          e_v;
  bit          e_tk;
  bit [31:0]   e_nx;
  bit          e_ok;
  string       e_ph;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_ctr[i] = 0; m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    m_hist = '0;
  endtask

  task automatic compare();
    chk(rsp_valid == e_v, {"R2 valid ", e_ph}, rsp_valid, e_v);
    if (e_v) begin
      chk(rsp_pred_taken == e_tk, {"R3 direction ", e_ph}, rsp_pred_taken, e_tk);
      chk(rsp_pred_next_pc == e_nx, {"R7 next pc ", e_ph}, rsp_pred_next_pc, e_nx);
      chk(rsp_correct == e_ok, {"R8 correct ", e_ph}, rsp_correct, e_ok);
    end
  endtask

  task automatic step(input bit v, input bit [31:0] pc, input bit tk,
                      input bit [31:0] nx, input string ph);
    bit [7:0] pi;
    bit [7:0] bi;
    bit       ptk;
    bit       hit;
    bit [31:0] pn;
    @(negedge clk);
    compare();
    req_valid = v; req_pc = pc; req_taken = tk; req_next_pc = nx;
    pi  = pc[9:2] ^ m_hist;
    bi  = pc[9:2];
    ptk = (m_ctr[pi] >= 2);
    hit = m_valid[bi] && (m_tag[bi] == pc[31:10]);
    pn  = (ptk && hit) ? m_tgt[bi] : pc + 32'd4;
    e_v = v; e_ph = ph;
    if (v) begin
      e_tk = ptk; e_nx = pn;
      e_ok = (ptk == tk) && (!ptk || pn == nx);
      if (tk) m_ctr[pi] = (m_ctr[pi] == 3) ? 3 : m_ctr[pi] + 1;
      else    m_ctr[pi] = (m_ctr[pi] == 0) ? 0 : m_ctr[pi] - 1;
      m_hist = {m_hist[6:0], tk};
      if (tk) begin
        m_valid[bi] = 1; m_tag[bi] = pc[31:10]; m_tgt[bi] = nx;
      end
    end
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_pc = '0; req_taken = 0; req_next_pc = '0;
    e_v = 0; e_tk = 0; e_nx = '0; e_ok = 0; e_ph = "reset";
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    chk(rsp_valid == 1'b0, "R1 reset valid", rsp_valid, 0);
    chk(rsp_pred_next_pc == 32'd0, "R1 reset next pc", rsp_pred_next_pc, 0);
    rst = 1'b0;

    // R1: first branch after reset sees cleared tables
    step(1, 32'h8000_0100, 1, 32'h8000_0040, "R1 first");
    // R4/R5: a loop branch taken many times, then falling through
    for (int i = 0; i < 20; i++) step(1, 32'h8000_0200, 1, 32'h8000_01C0, "R4 taken run");
    for (int i = 0; i < 12; i++) step(1, 32'h8000_0200, 0, 32'h8000_0204, "R4 not-taken run");
    // R5: alternating outcome, history-sensitive
    for (int i = 0; i < 24; i++) step(1, 32'h8000_0300, i[0], 32'h8000_0280, "R5 alternate");
    // R6: same slot, different tag; and not-taken must not overwrite
    for (int i = 0; i < 10; i++) step(1, 32'h8000_0040, 1, 32'h8000_0800, "R6 train A");
    for (int i = 0; i < 10; i++) step(1, 32'h9000_0040, 1, 32'h9000_0900, "R6 alias B");
    for (int i = 0; i < 4; i++)  step(1, 32'h8000_0040, 0, 32'h8000_0044, "R6 not-taken A");
    for (int i = 0; i < 6; i++)  step(1, 32'h9000_0040, 1, 32'h9000_0A00, "R6 new target");
    // R2: idle gaps must leave everything alone
    for (int i = 0; i < 8; i++) begin
      step(0, 32'h8000_0040, 1, 32'hDEAD_BEE0, "R2 idle");
      step(1, 32'h9000_0040, 1, 32'h9000_0A00, "R2 after idle");
    end
    // R9/R3: dense back-to-back mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] pc;
      bit [31:0] nx;
      pc = {($urandom % 2 == 0) ? 22'h200000 : 22'h240000, 4'b0, 4'($urandom), 2'b00};
      nx = {20'h80001, 10'($urandom), 2'b00};
      if ($urandom % 4 == 0) nx = pc + 32'd4;
      step(($urandom % 8) != 0, pc, ($urandom % 3) != 0, nx, "R9 mixed");
    end
    step(0, '0, 0, '0, "flush");
    @(negedge clk);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule